// File: doc/BRIEF.md
# PHY Reset and Power-Mode Sequencer

This block decides when each part of an Ethernet transceiver may run. It filters the active-low hardware reset so that short glitches are ignored. It latches the configuration and station-address straps, and it keeps a small bank of 16-bit management registers that hold their defaults. It then steps the analog, PLL and digital domains up in a fixed order. The sequencer waits for PLL lock, with a timeout as a limit.

Two low-power states are supported:

- **Hardware powerdown.** An input pin drives it. Everything is switched off and the management registers cannot be reached. Leaving it re-runs the whole power-up order, re-reads the straps and reloads register defaults.
- **Software powerdown.** A control-register bit sets it. Only clocking and register access stay alive. Leaving it re-initialises the digital logic and keeps every register value.

A software reset restores the register defaults but does not sample the straps again. While in hardware powerdown, an optional energy-detect wake mode raises an active-low interrupt when line energy appears.

Top module: `phy_pwr_seq`

## Requirements
- R1: A hardware reset takes effect only after `hw_rst_n` has been low for `RST_MIN_CYC` (default 25) consecutive clock cycles. A low pulse of fewer cycles changes no register and no output.
- R2: While a hardware reset is in effect, the following hold:
  - all domain enables, `sysclk_en` and `access_ok` are 0;
  - `cfg_strap` and `addr_strap` are latched every cycle;
  - the registers hold their defaults.
  After release, the block runs the power-up order of R5 without the strap-latch steps.
- R3: Writing a 1 to bit 15 of register 0 performs a software reset. All registers return to their defaults, computed from the configuration latched earlier; the straps are not sampled again. Afterwards bit 15 of register 0 reads back 0.
- R4: While `coma` is high (hardware powerdown), the following hold from the next cycle on:
  - `ana_en`, `dig_en`, `sysclk_en` and `access_ok` are 0;
  - reads return 0;
  - writes are dropped.
- R5: After `coma` falls, the enables come up in this order: `ana_en`, then `pll_en`, then a one-cycle `dig_init` pulse once the PLL is ready. Next `phy_addr` takes `addr_strap`. Then `cfg_lat` takes `cfg_strap` and the registers reload their defaults. Only then does `access_ok` rise.
- R6: Writing a 1 to bit 11 of register 0 enters software powerdown. In that state `ana_en` and `dig_en` are 0, `pll_en` is 1, and register reads and writes remain allowed.
- R7: In software powerdown, `sysclk_en` equals bit 4 of register 22.
- R8: Writing register 0 with bit 11 clear during software powerdown gives a one-cycle `dig_init` pulse, followed by normal operation. Register contents, `phy_addr` and `cfg_lat` are unchanged.
- R9: Energy-detect mode is active while the block is in hardware powerdown and `edet_en_n` is low. In that mode, `line_energy` high drives `int_n` low. `int_n` stays low until energy-detect mode ends. With `edet_en_n` high, `int_n` stays 1.
- R10: `dig_init` follows the rise of `pll_en` as soon as `pll_locked` is high. If lock never comes, it follows exactly `PLL_TMO` cycles after `pll_en` rises.
- R11: A hardware reset overrides `coma`, and `coma` overrides software powerdown. Asserting `coma` during software powerdown leads, on exit, to the full sequence of R5, which clears bit 11.
- R12: The register defaults are as follows, with `cfg_strap` bits c0 to c3:
  - register 0 has bit 12 = c0, bit 8 = c2 and bit 6 = c3, all other bits 0;
  - register 22 has bit 4 = c1, all other bits 0;
  - all other registers are 0.
  Registers other than 0 store whatever is written to them while `access_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| hw_rst_n | input | 1 | Raw active-low hardware reset |
| coma | input | 1 | Hardware powerdown request |
| edet_en_n | input | 1 | Active-low energy-detect enable strap |
| line_energy | input | 1 | Line energy present |
| cfg_strap | input | 4 | Configuration straps |
| addr_strap | input | 5 | Station address straps |
| pll_locked | input | 1 | PLL lock indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (0 when refused) |
| ana_en | output | 1 | Analog domain enable |
| pll_en | output | 1 | PLL enable |
| dig_en | output | 1 | Digital domain enable |
| dig_init | output | 1 | One-cycle digital re-initialisation pulse |
| sysclk_en | output | 1 | System clock output enable |
| int_n | output | 1 | Active-low energy interrupt |
| cfg_lat | output | 4 | Latched configuration |
| phy_addr | output | 5 | Latched station address |
| access_ok | output | 1 | Register access allowed |

## Verification
The bench probes the reset filter one cycle either side of its threshold. A filter that is off by one either drops a legal reset or clears a register on a 24-cycle glitch. It changes the straps before a software reset and before a powerdown exit, so that a design confusing the two paths shows the wrong `phy_addr` or wrong register-0 defaults. It times the power-up order cycle by cycle, including the lock timeout. A design that opens access early or miscounts the wait shows up there. It also checks three more cases:

- the interrupt with energy detect disabled;
- powerdown entered from software powerdown;
- a reset released while `coma` is still high.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int NREGS = 1 << AW;

  localparam logic [AW-1:0] CTRL_REG = 5'd0;
  localparam logic [AW-1:0] CLKO_REG = 5'd22;
  localparam int SWRST_BIT = 15;
  localparam int SWPD_BIT  = 11;
  localparam int CLKO_BIT  = 4;

  typedef enum logic [3:0] {
    ST_HWRST, ST_ANA, ST_PLL, ST_DIG, ST_ADDR,
    ST_LOAD, ST_RUN, ST_SWRST, ST_SWPD, ST_COMA
  } pwr_state_e;

  typedef struct packed {
    logic ana;
    logic pll;
    logic dig;
    logic clk_out_ok;
    logic access;
  } pwr_en_t;

  function automatic logic [DW-1:0] reg_default(input logic [AW-1:0] a,
                                                input logic [CW-1:0] cfg);
    logic [DW-1:0] v;
    v = '0;
    if (a == CTRL_REG) begin
      v[12] = cfg[0];
      v[8]  = cfg[2];
      v[6]  = cfg[3];
    end else if (a == CLKO_REG) begin
      v[CLKO_BIT] = cfg[1];
    end
    return v;
  endfunction

  function automatic pwr_en_t state_enables(input pwr_state_e s);
    pwr_en_t e;
    e = '0;
    case (s)
      ST_ANA:  e.ana = 1'b1;
      ST_PLL:  begin e.ana = 1'b1; e.pll = 1'b1; end
      ST_DIG, ST_ADDR, ST_LOAD, ST_SWRST: begin
        e.ana = 1'b1; e.pll = 1'b1; e.dig = 1'b1; e.clk_out_ok = 1'b1;
      end
      ST_RUN:  begin
        e.ana = 1'b1; e.pll = 1'b1; e.dig = 1'b1; e.clk_out_ok = 1'b1;
        e.access = 1'b1;
      end
      ST_SWPD: begin e.pll = 1'b1; e.clk_out_ok = 1'b1; e.access = 1'b1; end
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/phy_rst_filter.sv
module phy_rst_filter #(
  parameter int MIN_CYC = 25
) (
  input  logic clk,
  input  logic raw_n,
  output logic rst_active
);
  localparam int CNT_W = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_CYC);

  logic [CNT_W-1:0] low_cnt = '0;

  always_ff @(posedge clk) begin
    if (raw_n)                low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign rst_active = (low_cnt == LIMIT);
endmodule

// File: rtl/phy_pwr_fsm.sv
module phy_pwr_fsm
  import phy_pwr_pkg::*;
#(
  parameter int PLL_TMO = 16
) (
  input  logic       clk,
  input  logic       hw_rst,
  input  logic       coma,
  input  logic       pll_locked,
  input  logic       ctl_hit,
  input  logic       ctl_swrst,
  input  logic       ctl_swpd,
  output pwr_state_e state,
  output logic       wake_from_coma
);
  localparam int TW = $clog2(PLL_TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(PLL_TMO - 1);

  pwr_state_e nxt;
  logic [TW-1:0] tmr;
  logic tmo;

  assign tmo = (tmr == TMO_LAST);

  always_comb begin
    nxt = state;
    if (coma) nxt = ST_COMA;
    else begin
      case (state)
        ST_HWRST: nxt = ST_ANA;
        ST_COMA:  nxt = ST_ANA;
        ST_ANA:   nxt = ST_PLL;
        ST_PLL:   if (pll_locked || tmo) nxt = ST_DIG;
        ST_DIG:   nxt = wake_from_coma ? ST_ADDR : ST_RUN;
        ST_ADDR:  nxt = ST_LOAD;
        ST_LOAD:  nxt = ST_RUN;
        ST_SWRST: nxt = ST_DIG;
        ST_RUN: if (ctl_hit) begin
          if (ctl_swrst)     nxt = ST_SWRST;
          else if (ctl_swpd) nxt = ST_SWPD;
        end
        ST_SWPD: if (ctl_hit) begin
          if (ctl_swrst)      nxt = ST_SWRST;
          else if (!ctl_swpd) nxt = ST_DIG;
        end
        default: nxt = ST_HWRST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      state          <= ST_HWRST;
      tmr            <= '0;
      wake_from_coma <= 1'b0;
    end else begin
      state <= nxt;
      tmr   <= (state == ST_PLL) ? tmr + 1'b1 : '0;
      if (state == ST_COMA)      wake_from_coma <= 1'b1;
      else if (state == ST_LOAD) wake_from_coma <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_pwr_pkg::*;
(
  input  logic          clk,
  input  logic          load_def,
  input  logic [CW-1:0] def_cfg,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctrl_val,
  output logic [DW-1:0] clko_val
);
  logic [DW-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (load_def)
        regs[i] <= reg_default(AW'(i), def_cfg);
      else if (wr_en && wr_addr == AW'(i))
        regs[i] <= wr_data;
    end
  end

  assign rd_data  = regs[rd_addr];
  assign ctrl_val = regs[CTRL_REG];
  assign clko_val = regs[CLKO_REG];
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int RST_MIN_CYC = 25,
  parameter int PLL_TMO     = 16
) (
  input  logic          clk,
  input  logic          hw_rst_n,
  input  logic          coma,
  input  logic          edet_en_n,
  input  logic          line_energy,
  input  logic [CW-1:0] cfg_strap,
  input  logic [AW-1:0] addr_strap,
  input  logic          pll_locked,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          ana_en,
  output logic          pll_en,
  output logic          dig_en,
  output logic          dig_init,
  output logic          sysclk_en,
  output logic          int_n,
  output logic [CW-1:0] cfg_lat,
  output logic [AW-1:0] phy_addr,
  output logic          access_ok
);
  logic          hw_rst;
  pwr_state_e    state;
  pwr_en_t       en;
  logic          wake_from_coma;
  logic          wr_ok, rd_ok, ctl_hit;
  logic          load_def, cfg_win, addr_win, edet_mode, int_flag;
  logic [CW-1:0] def_cfg;
  logic [DW-1:0] bank_rd, ctrl_val, clko_val;
  logic          clko_bit;

  phy_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_filt (
    .clk(clk), .raw_n(hw_rst_n), .rst_active(hw_rst)
  );

  phy_pwr_fsm #(.PLL_TMO(PLL_TMO)) u_fsm (
    .clk(clk), .hw_rst(hw_rst), .coma(coma), .pll_locked(pll_locked),
    .ctl_hit(ctl_hit), .ctl_swrst(reg_wdata[SWRST_BIT]),
    .ctl_swpd(reg_wdata[SWPD_BIT]), .state(state),
    .wake_from_coma(wake_from_coma)
  );

  assign en        = state_enables(state);
  assign access_ok = en.access;
  assign wr_ok     = reg_wr && access_ok;
  assign rd_ok     = reg_rd && access_ok;
  assign ctl_hit   = wr_ok && (reg_addr == CTRL_REG);

  assign cfg_win  = hw_rst || (state == ST_LOAD);
  assign addr_win = hw_rst || (state == ST_ADDR);
  assign load_def = cfg_win || (state == ST_SWRST);
  assign def_cfg  = cfg_win ? cfg_strap : cfg_lat;

  phy_reg_bank u_bank (
    .clk(clk), .load_def(load_def), .def_cfg(def_cfg),
    .wr_en(wr_ok), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .rd_addr(reg_addr), .rd_data(bank_rd),
    .ctrl_val(ctrl_val), .clko_val(clko_val)
  );

  always_ff @(posedge clk) begin
    if (cfg_win)  cfg_lat  <= cfg_strap;
    if (addr_win) phy_addr <= addr_strap;
  end

  assign edet_mode = (state == ST_COMA) && !edet_en_n;

  always_ff @(posedge clk) begin
    if (hw_rst || !edet_mode) int_flag <= 1'b0;
    else if (line_energy)     int_flag <= 1'b1;
    else if (rd_ok)           int_flag <= 1'b0;
  end

  assign clko_bit  = clko_val[CLKO_BIT];
  assign reg_rdata = access_ok ? bank_rd : '0;
  assign ana_en    = en.ana;
  assign pll_en    = en.pll;
  assign dig_en    = en.dig;
  assign dig_init  = (state == ST_DIG);
  assign sysclk_en = en.clk_out_ok && clko_bit;
  assign int_n     = !int_flag;
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk (
  input logic        clk,
  input logic        hw_rst,
  input logic        coma,
  input logic        edet_en_n,
  input logic        line_energy,
  input logic        int_n,
  input logic        ana_en,
  input logic        pll_en,
  input logic        dig_en,
  input logic        sysclk_en,
  input logic        access_ok,
  input logic [4:0]  reg_addr,
  input logic [15:0] reg_rdata,
  input logic [4:0]  phy_addr,
  input logic        addr_win,
  input logic        clko_bit
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (hw_rst) armed <= 1'b1;

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!armed)
    hw_rst |=> (!ana_en && !pll_en && !dig_en && !sysclk_en && !access_ok));

  assert_coma_off_R4: assert property (@(posedge clk) disable iff (!armed)
    coma |=> (!ana_en && !dig_en && !sysclk_en && !access_ok));

  assert_dig_needs_pll_R10: assert property (@(posedge clk) disable iff (!armed)
    dig_en |-> pll_en);

  assert_int_source_R9: assert property (@(posedge clk) disable iff (!armed || hw_rst)
    $fell(int_n) |-> ($past(line_energy) && !$past(edet_en_n)));

  assert_int_hold_R9: assert property (@(posedge clk) disable iff (!armed || hw_rst)
    (!int_n && coma && !edet_en_n) |=> !int_n);

  assert_swrst_clear_R3: assert property (@(posedge clk) disable iff (!armed)
    (access_ok && reg_addr == 5'd0) |-> !reg_rdata[15]);

  assert_clko_swpd_R7: assert property (@(posedge clk) disable iff (!armed)
    (access_ok && !ana_en) |-> (sysclk_en == clko_bit));

  assert_addr_latch_R5: assert property (@(posedge clk) disable iff (!armed)
    !$stable(phy_addr) |-> ($past(hw_rst) || $past(addr_win)));

  assert_access_last_R5: assert property (@(posedge clk) disable iff (!armed)
    $rose(access_ok) |-> (dig_en && pll_en && ana_en));
endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
  .clk(clk), .hw_rst(hw_rst), .coma(coma), .edet_en_n(edet_en_n),
  .line_energy(line_energy), .int_n(int_n), .ana_en(ana_en),
  .pll_en(pll_en), .dig_en(dig_en), .sysclk_en(sysclk_en),
  .access_ok(access_ok), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .phy_addr(phy_addr), .addr_win(addr_win), .clko_bit(clko_bit)
);

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic hw_rst_n = 1'b0, coma = 1'b0, edet_en_n = 1'b1, line_energy = 1'b0;
  logic [3:0] cfg_strap = 4'b1011;
  logic [4:0] addr_strap = 5'h0A;
  logic pll_locked = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ana_en, pll_en, dig_en, dig_init, sysclk_en, int_n, access_ok;
  logic [3:0] cfg_lat;
  logic [4:0] phy_addr;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [32];

  always #10 clk = ~clk;

  phy_pwr_seq #(.RST_MIN_CYC(25), .PLL_TMO(TMO)) u_phy_pwr_seq (
    .clk(clk), .hw_rst_n(hw_rst_n), .coma(coma), .edet_en_n(edet_en_n),
    .line_energy(line_energy), .cfg_strap(cfg_strap), .addr_strap(addr_strap),
    .pll_locked(pll_locked), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ana_en(ana_en), .pll_en(pll_en), .dig_en(dig_en), .dig_init(dig_init),
    .sysclk_en(sysclk_en), .int_n(int_n), .cfg_lat(cfg_lat),
    .phy_addr(phy_addr), .access_ok(access_ok)
  );

  function automatic logic [15:0] exp_def(input int a, input logic [3:0] c);
    if (a == 0)  return (16'(c[0]) << 12) | (16'(c[2]) << 8) | (16'(c[3]) << 6);
    if (a == 22) return 16'(c[1]) << 4;
    return 16'h0;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    reg_addr = 5'(a); reg_rd = 1'b1;
    #1 v = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic wait_access(input string tag);
    int k = 0;
    while (!access_ok && k < 200) begin tick(); k++; end
    chk(access_ok, tag, 0, 1);
  endtask

  task automatic defaults_ok(input logic [3:0] c, input string tag);
    logic [15:0] v;
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      chk(v == exp_def(a, c), tag, v, exp_def(a, c));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int c_ana, c_pll, c_init, c_addr, c_acc, cyc;
    void'($urandom(32'd1234));
    tick(30);
    // R2: outputs quiet while held in reset
    chk(!ana_en && !pll_en && !dig_en && !access_ok && !sysclk_en, "R2 quiet", ana_en, 0);
    hw_rst_n = 1'b1;
    wait_access("R2 access after reset");
    chk(phy_addr == 5'h0A, "R2 addr latch", phy_addr, 5'h0A);
    chk(cfg_lat == 4'b1011, "R2 cfg latch", cfg_lat, 4'b1011);
    defaults_ok(4'b1011, "R12 defaults after reset");

    // R1: 24-cycle glitch ignored, 25-cycle pulse accepted
    wr(5, 16'h1234);
    hw_rst_n = 1'b0; tick(24); hw_rst_n = 1'b1; tick();
    chk(access_ok, "R1 short pulse access", access_ok, 1);
    rd(5, v); chk(v == 16'h1234, "R1 short pulse ignored", v, 16'h1234);
    hw_rst_n = 1'b0; tick(25); hw_rst_n = 1'b1; tick();
    wait_access("R1 long pulse recovery");
    rd(5, v); chk(v == 16'h0, "R1 long pulse resets", v, 0);

    // R12: random register traffic
    for (int a = 0; a < 32; a++) mdl[a] = exp_def(a, 4'b1011);
    for (int i = 0; i < 60; i++) begin
      int a;
      a = 1 + int'($urandom_range(30));
      if ($urandom_range(1) == 1) begin
        logic [15:0] d;
        d = 16'($urandom);
        wr(a, d); mdl[a] = d;
      end else begin
        rd(a, v); chk(v == mdl[a], "R12 random rw", v, mdl[a]);
      end
    end

    // R3: software reset keeps old straps
    cfg_strap = 4'b0100; addr_strap = 5'h11;
    wr(5, 16'hBEEF);
    wr(0, 16'h8000);
    wait_access("R3 access after swrst");
    defaults_ok(4'b1011, "R3 defaults from old cfg");
    chk(phy_addr == 5'h0A, "R3 addr not resampled", phy_addr, 5'h0A);
    chk(cfg_lat == 4'b1011, "R3 cfg not resampled", cfg_lat, 4'b1011);

    // R6 / R7: software powerdown
    wr(22, 16'h0010);
    wr(0, 16'h0800);
    chk(!ana_en && !dig_en && pll_en && access_ok, "R6 swpd enables", {ana_en, dig_en, pll_en, access_ok}, 4'b0011);
    chk(sysclk_en, "R7 sysclk on", sysclk_en, 1);
    wr(22, 16'h0000);
    chk(!sysclk_en, "R7 sysclk off", sysclk_en, 0);
    wr(22, 16'h0010);
    wr(7, 16'h5555);
    rd(7, v); chk(v == 16'h5555, "R6 write in swpd", v, 16'h5555);

    // R8: leave software powerdown
    wr(0, 16'h0000);
    #1 chk(dig_init && !access_ok, "R8 dig_init pulse", dig_init, 1);
    tick();
    chk(access_ok && dig_en && !dig_init, "R8 back to run", access_ok, 1);
    rd(7, v); chk(v == 16'h5555, "R8 reg kept", v, 16'h5555);
    rd(22, v); chk(v == 16'h0010, "R8 clko kept", v, 16'h0010);
    chk(phy_addr == 5'h0A, "R8 addr kept", phy_addr, 5'h0A);

    // R4 / R9: hardware powerdown with energy detect
    edet_en_n = 1'b0; coma = 1'b1; tick(2);
    chk(!ana_en && !dig_en && !sysclk_en && !access_ok, "R4 all off", ana_en, 0);
    rd(7, v); chk(v == 16'h0, "R4 read refused", v, 0);
    chk(int_n, "R9 no energy no int", int_n, 1);
    line_energy = 1'b1; tick(); line_energy = 1'b0; tick();
    chk(!int_n, "R9 int asserted", int_n, 0);
    tick(5);
    chk(!int_n, "R9 int held", int_n, 0);

    // R5: exit order with late lock
    cfg_strap = 4'b0110; addr_strap = 5'h15; pll_locked = 1'b0;
    coma = 1'b0;
    c_ana = -1; c_pll = -1; c_init = -1; c_addr = -1; c_acc = -1;
    for (cyc = 0; cyc < 100 && c_acc < 0; cyc++) begin
      tick();
      if (ana_en && c_ana < 0) c_ana = cyc;
      if (pll_en && c_pll < 0) c_pll = cyc;
      if (c_pll >= 0 && cyc == c_pll + 3) pll_locked = 1'b1;
      if (dig_init && c_init < 0) c_init = cyc;
      if (phy_addr == 5'h15 && c_addr < 0) c_addr = cyc;
      if (access_ok && c_acc < 0) c_acc = cyc;
    end
    chk(int_n, "R9 int cleared on exit", int_n, 1);
    chk(c_ana >= 0 && c_ana < c_pll, "R5 ana before pll", c_ana, c_pll);
    chk(c_pll < c_init, "R5 pll before init", c_pll, c_init);
    chk(c_init == c_pll + 4, "R10 lock ends wait", c_init, c_pll + 4);
    chk(c_init < c_addr && c_addr < c_acc, "R5 addr between init and access", c_addr, c_acc);
    chk(cfg_lat == 4'b0110, "R5 cfg relatched", cfg_lat, 4'b0110);
    defaults_ok(4'b0110, "R5 defaults from new cfg");

    // R9: energy detect disabled
    edet_en_n = 1'b1; coma = 1'b1; line_energy = 1'b1; tick(6);
    chk(int_n, "R9 disabled no int", int_n, 1);
    line_energy = 1'b0; pll_locked = 1'b0; coma = 1'b0;

    // R10: lock never comes
    c_pll = -1; c_init = -1;
    for (cyc = 0; cyc < 100 && c_init < 0; cyc++) begin
      tick();
      if (pll_en && c_pll < 0) c_pll = cyc;
      if (dig_init && c_init < 0) c_init = cyc;
    end
    chk(c_init - c_pll == TMO, "R10 timeout length", c_init - c_pll, TMO);
    pll_locked = 1'b1;
    wait_access("R10 access after timeout");

    // R11: coma overrides software powerdown
    wr(0, 16'h0800); wr(9, 16'h0AAA);
    coma = 1'b1; tick(2);
    chk(!access_ok && !pll_en, "R11 coma over swpd", pll_en, 0);
    coma = 1'b0;
    wait_access("R11 access after coma");
    rd(0, v); chk(v == exp_def(0, 4'b0110), "R11 swpd bit cleared", v, exp_def(0, 4'b0110));
    rd(9, v); chk(v == 16'h0, "R11 full restore", v, 0);

    // R11: reset released while coma held stays down
    coma = 1'b1; hw_rst_n = 1'b0; tick(30); hw_rst_n = 1'b1; tick(5);
    chk(!ana_en && !pll_en && !access_ok, "R11 coma after reset", ana_en, 0);
    coma = 1'b0;
    wait_access("R11 recovery");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule